// File: doc/BRIEF.md
# Time-Shared Quadratic Evaluator

This block evaluates the signed polynomial y = A·x² + B·x + C with a single multiplier and a single adder. Both operators are reused across consecutive clock cycles: a small sequencer steers operands into them through multiplexers and decides which intermediate register captures each result. The block trades throughput for area. One evaluation occupies the datapath for several cycles, and a new sample cannot enter until the previous result has been written.

A caller drives the coefficients and a sample, then raises `start` for one cycle while the block is idle. The sample is captured on that edge, so it may change afterwards. The coefficients must stay steady until `done` pulses. When `done` pulses, `y` holds the finished result, and `y` keeps that value until the next evaluation completes. The result width is wide enough that no combination of W-bit signed inputs can overflow it.

The reset `rst_n` is active low and asynchronous. Its deassertion is expected to be synchronised to `clk` before it reaches the block.

Top module: `quad_shared_eval`

## Requirements
- R1: When `done` is high, `y`, read as a signed (3W+2)-bit value, equals A·x² + B·x + C exactly. Here x is the sample present on the accepting edge and A, B, C are the coefficient inputs held during the evaluation. At most one intermediate register loads in any cycle.
- R2: `done` is high for exactly one cycle. It rises on the fourth rising clock edge after the edge that accepts `start`.
- R3: `y` changes only on the edge where `done` rises. Between completions it holds its last value.
- R4: A `start` that is high while an evaluation is in progress is ignored. The running result and its `done` timing are unaffected, and no extra result is produced.
- R5: `start` is accepted whenever the block is idle. Changes to `x_in` after the accepting edge do not alter the result.
- R6: While `rst_n` is low, `y` reads 0 and `done` reads 0. Asserting `rst_n` low in the middle of an evaluation cancels it, so no `done` follows.
- R7: A `start` presented during the cycle in which `done` is high is accepted. The next `done` rises four edges after that acceptance.
- R8: Extreme inputs produce correct results without overflow, including every operand at its most negative value (-2^(W-1)) and mixed most-positive and most-negative cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an evaluation; acted on only when idle |
| a_in | input | W | Signed coefficient of x² |
| b_in | input | W | Signed coefficient of x |
| c_in | input | W | Signed constant term |
| x_in | input | W | Signed sample, captured when start is accepted |
| y | output | 3W+2 | Signed result register |
| done | output | 1 | One-cycle pulse marking that y has just been written |

## Verification
Two events can share a cycle. The completion pulse of one evaluation can coincide with the acceptance of the next `start`, and a busy-time `start` can arrive in the same cycle as the sequencer's final load steps. The bench drives a new `start` in the very cycle in which `done` is observed high. It also holds `start` high through the busy cycles while scrambling `x_in`. A cycle-accurate behavioural model predicts, on every clock, when `done` should rise and what `y` should read. Any extra or early acceptance then shows up as a mismatch in either the pulse timing or the value.

// File: rtl/qe_pkg.sv
package qe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SQ   = 3'd1,
    ST_BX   = 3'd2,
    ST_ACC  = 3'd3,
    ST_FIN  = 3'd4
  } qe_state_e;

  // second multiplier operand choice
  typedef enum logic [1:0] {
    MB_X = 2'd0,
    MB_B = 2'd1,
    MB_A = 2'd2
  } mb_sel_e;

  typedef struct packed {
    logic    ld_x;
    logic    ld_xx;
    logic    ld_bxc;
    logic    ld_y;
    logic    ma_sq;   // 1: first operand is x*x register, 0: x register
    mb_sel_e mb_sel;
    logic    ad_acc;  // 1: adder takes stored B*x+C, 0: takes C
  } qe_ctl_t;

endpackage

// File: rtl/qe_ldreg.sv
module qe_ldreg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/qe_ctrl.sv
module qe_ctrl
  import qe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  output qe_ctl_t ctl,
  output logic    done
);

  qe_state_e state, state_nx;

  always_comb begin
    state_nx   = state;
    ctl        = '0;
    ctl.mb_sel = MB_X;
    unique case (state)
      ST_IDLE: begin
        ctl.ld_x = start;
        if (start) state_nx = ST_SQ;
      end
      ST_SQ: begin
        ctl.ma_sq  = 1'b0;
        ctl.mb_sel = MB_X;
        state_nx   = ST_BX;
      end
      ST_BX: begin
        ctl.ld_xx  = 1'b1;
        ctl.ma_sq  = 1'b0;
        ctl.mb_sel = MB_B;
        state_nx   = ST_ACC;
      end
      ST_ACC: begin
        ctl.ma_sq  = 1'b1;
        ctl.mb_sel = MB_A;
        ctl.ad_acc = 1'b0;
        ctl.ld_bxc = 1'b1;
        state_nx   = ST_FIN;
      end
      ST_FIN: begin
        ctl.ad_acc = 1'b1;
        ctl.ld_y   = 1'b1;
        state_nx   = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= ctl.ld_y;
    end
  end

  // R4: the first computing step is only ever entered from idle
  p_enter_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SQ) |-> ($past(state) == ST_IDLE));

endmodule

// File: rtl/qe_datapath.sv
module qe_datapath
  import qe_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  qe_ctl_t                ctl,
  input  logic signed [W-1:0]    a_in,
  input  logic signed [W-1:0]    b_in,
  input  logic signed [W-1:0]    c_in,
  input  logic signed [W-1:0]    x_in,
  output logic signed [3*W+1:0]  y
);

  localparam int XXW = 2 * W;     // x*x fits in 2W signed bits
  localparam int PRW = 3 * W;     // widest product A*(x*x)
  localparam int SW  = 3 * W + 2; // sum width

  logic signed [W-1:0]   x_r;
  logic signed [XXW-1:0] xx_r;
  logic signed [PRW-1:0] prod_r;
  logic signed [SW-1:0]  bxc_r;

  logic signed [XXW-1:0] ma_op;
  logic signed [W-1:0]   mb_op;
  logic signed [PRW-1:0] prod_nx;
  logic signed [SW-1:0]  prod_ext;
  logic signed [SW-1:0]  ad_op;
  logic signed [SW-1:0]  sum;

  // operand steering for the shared multiplier
  always_comb begin
    ma_op = ctl.ma_sq ? xx_r : {{(XXW-W){x_r[W-1]}}, x_r};
    unique case (ctl.mb_sel)
      MB_X:    mb_op = x_r;
      MB_B:    mb_op = b_in;
      MB_A:    mb_op = a_in;
      default: mb_op = '0;
    endcase
  end

  assign prod_nx = ma_op * mb_op;

  // shared adder: one leg is always the registered product
  assign prod_ext = {{(SW-PRW){prod_r[PRW-1]}}, prod_r};
  assign ad_op    = ctl.ad_acc ? bxc_r : {{(SW-W){c_in[W-1]}}, c_in};
  assign sum      = prod_ext + ad_op;

  qe_ldreg #(.WIDTH(W)) u_x_reg (
    .clk(clk), .rst_n(rst_n), .en(ctl.ld_x), .d(x_in), .q(x_r));

  qe_ldreg #(.WIDTH(PRW)) u_prod_reg (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .d(prod_nx), .q(prod_r));

  qe_ldreg #(.WIDTH(XXW)) u_xx_reg (
    .clk(clk), .rst_n(rst_n), .en(ctl.ld_xx), .d(prod_r[XXW-1:0]), .q(xx_r));

  qe_ldreg #(.WIDTH(SW)) u_bxc_reg (
    .clk(clk), .rst_n(rst_n), .en(ctl.ld_bxc), .d(sum), .q(bxc_r));

  qe_ldreg #(.WIDTH(SW)) u_y_reg (
    .clk(clk), .rst_n(rst_n), .en(ctl.ld_y), .d(sum), .q(y));

  // R1: the sequencer never loads two intermediate registers at once
  p_single_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.ld_x, ctl.ld_xx, ctl.ld_bxc, ctl.ld_y}));

  // R8: the final sum keeps a redundant sign bit, so it never wraps
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ld_y |-> (sum[SW-1] == sum[SW-2]));

endmodule

// File: rtl/quad_shared_eval.sv
module quad_shared_eval
  import qe_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic signed [W-1:0]   a_in,
  input  logic signed [W-1:0]   b_in,
  input  logic signed [W-1:0]   c_in,
  input  logic signed [W-1:0]   x_in,
  output logic signed [3*W+1:0] y,
  output logic                  done
);

  qe_ctl_t ctl;

  qe_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .ctl   (ctl),
    .done  (done)
  );

  qe_datapath #(.W(W)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .a_in  (a_in),
    .b_in  (b_in),
    .c_in  (c_in),
    .x_in  (x_in),
    .y     (y)
  );

  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: the result register moves only together with the completion pulse
  p_y_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (y != $past(y)) |-> done);

endmodule

// File: tb/tb_quad_shared_eval.sv
module tb_quad_shared_eval;
  localparam int W  = 16;
  localparam int YW = 3 * W + 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                  rst_n;
  logic                  start;
  logic signed [W-1:0]   a_in, b_in, c_in, x_in;
  logic signed [YW-1:0]  y;
  logic                  done;

  quad_shared_eval #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_in(a_in), .b_in(b_in), .c_in(c_in), .x_in(x_in),
    .y(y), .done(done));

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  bit     m_busy;
  int     m_cnt;
  longint m_pend, m_y;
  bit     m_done;

  function automatic longint ref_q(longint a, longint b, longint c, longint x);
    return a * x * x + b * x + c;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    bit was_busy;
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_y = 0; m_done = 0; m_pend = 0;
    end else begin
      was_busy = m_busy;
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 4) begin
          m_y = m_pend; m_done = 1; m_busy = 0;
        end
      end
      if (!was_busy && start) begin
        m_busy = 1; m_cnt = 0;
        m_pend = ref_q(longint'(a_in), longint'(b_in), longint'(c_in), longint'(x_in));
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    longint ey;
    bit ed;
    if (!rst_n) begin ey = 0; ed = 0; end
    else begin ey = m_y; ed = m_done; end
    chk(done == ed, "R2 done timing vs model", longint'(done), longint'(ed));
    chk(longint'(y) == ey, "R1/R3 y vs model", longint'(y), ey);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++; n_chk++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // one evaluation: optional busy-time start pokes and x scrambling
  task automatic eval(longint a, longint b, longint c, longint x,
                      bit now, bit poke, bit scramble, string req);
    int n;
    longint exp;
    if (now) #1;
    else begin @(posedge clk); #2; end
    a_in = W'(a); b_in = W'(b); c_in = W'(c); x_in = W'(x);
    start = 1'b1;
    exp = ref_q(a, b, c, x);
    @(posedge clk);
    n = 0;
    for (int k = 1; k <= 8; k++) begin
      #2;
      start = (poke && k <= 3);
      if (poke) x_in = ~W'(x);
      if (scramble) x_in = W'($urandom);
      @(negedge clk);
      if (done) begin n = k; break; end
      @(posedge clk);
    end
    start = 1'b0;
    chk(longint'(y) == exp, req, longint'(y), exp);
    chk(n == 5, "R2 done on fourth edge after accept", n, 5);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    a_in = '0; b_in = '0; c_in = '0; x_in = '0;
    repeat (3) @(negedge clk);
    chk(y == '0 && done == 1'b0, "R6 reset state", longint'(y), 0);
    @(posedge clk); #2; rst_n = 1'b1;

    eval(3, -5, 7, 11, 0, 0, 0, "R1 basic value");
    eval(-2, 4, -9, -6, 0, 0, 1, "R5 x change after accept ignored");
    eval(5, 1, 2, 3, 0, 1, 0, "R4 busy start ignored");
    // R7: next start issued in the done cycle
    eval(7, 7, 7, 100, 1, 0, 0, "R7 back-to-back start");
    eval(-1, -1, -1, -1, 0, 0, 0, "R1 all minus one");

    // R8 extremes
    eval(-32768, -32768, -32768, -32768, 0, 0, 0, "R8 all most negative");
    eval(32767, 32767, 32767, -32768, 0, 0, 0, "R8 max coeffs min x");
    eval(-32768, 32767, -32768, 32767, 0, 0, 0, "R8 mixed extremes");
    eval(32767, -32768, 32767, 32767, 0, 1, 0, "R8 max x with pokes");
    eval(0, 0, 0, 0, 0, 0, 0, "R1 zero");

    for (int i = 0; i < 40; i++) begin
      eval(longint'($signed(W'($urandom))), longint'($signed(W'($urandom))),
           longint'($signed(W'($urandom))), longint'($signed(W'($urandom))),
           i[0], i[1], i[2], "R1 random");
    end

    // R6: reset in the middle of an evaluation cancels it
    @(posedge clk); #2;
    a_in = 16'sd9; b_in = 16'sd9; c_in = 16'sd9; x_in = 16'sd9; start = 1'b1;
    @(posedge clk); #2; start = 1'b0;
    @(posedge clk); #2; rst_n = 1'b0;
    @(negedge clk);
    chk(y == '0 && done == 1'b0, "R6 mid-run reset clears", longint'(y), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (done) seen++;
      end
      chk(seen == 0, "R6 cancelled run gives no done", seen, 0);
    end
    chk(y == '0, "R3 y held at zero after cancel", longint'(y), 0);

    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule